// File: doc/BRIEF.md
# CAN Error and Warning Status Register

This block is the error and status word of a CAN controller, together with the interrupt logic behind it. The protocol engine gives it single-cycle pulses for six kinds of bus error: bit-1, bit-0, acknowledge, CRC, form and stuffing. The engine also gives it the live transmit and receive error counter values. The block holds each error as a sticky flag. It compares both counters against a warning limit and shows the result as two live status bits. It raises a warning interrupt flag when either status bit goes from 0 to 1, provided warnings are enabled.

Software sees one 32-bit word through a read strobe and a write strobe. The word uses two clearing styles. Any read clears the six error flags. The two warning interrupt flags are cleared by writing a 1 to their bit, and writing 0 to that bit leaves it unchanged. Each warning interrupt flag has its own mask. The interrupt request is the registered OR of the two masked warning flags.

Bit numbers below count from the least significant bit (LSB = 0) of `rd_data`/`wr_data`.

Top module: `can_err_stat`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 0 (with both counters below the limit) and `irq` is 0.
- R2: Bit 9 reads 1 exactly when `tx_err_cnt` >= 96. Bit 8 reads 1 exactly when `rx_err_cnt` >= 96. Both follow the counters in the same cycle.
- R3: Error flags sit at bit-1 = bit 15, bit-0 = 14, acknowledge = 13, CRC = 12, form = 11, stuffing = 10. Each is set by its pulse on the edge that samples the pulse, and stays set while there are no reads.
- R4: A read (`rd_en` = 1) clears all six error flags on that edge. An error pulse on the same edge as a read leaves its flag set.
- R5: A bit-1 error pulse has no effect while `bit1_exempt` is 1. This input covers the arbitration field, the ACK slot and the sending of a passive error flag.
- R6: The transmit warning interrupt flag (bit 17) and the receive warning interrupt flag (bit 16) set on the edge where the matching status bit goes from 0 to 1. They set only if `warn_en` is 1 at that edge.
- R7: A status bit that is already 1 when `warn_en` rises does not set its interrupt flag. The flag sets only on a later 0-to-1 change of that status bit.
- R8: Writing 1 to bit 17 or bit 16 clears that flag. Writing 0 leaves it unchanged, and reads do not clear it. A warning edge on the same edge as a clearing write leaves the flag set.
- R9: `irq` equals (bit 17 AND `tx_warn_mask`) OR (bit 16 AND `rx_warn_mask`), delayed by one clock.
- R10: Bits 31..18 and 7..0 always read 0. Writes have no effect on any bit other than 17 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_bit1 | input | 1 | Bit-1 error pulse (sent recessive, seen dominant) |
| ev_bit0 | input | 1 | Bit-0 error pulse (sent dominant, seen recessive) |
| ev_ack | input | 1 | Acknowledge error pulse |
| ev_crc | input | 1 | CRC error pulse |
| ev_form | input | 1 | Form error pulse |
| ev_stuff | input | 1 | Stuffing error pulse |
| bit1_exempt | input | 1 | Blocks bit-1 error pulses when 1 |
| tx_err_cnt | input | 8 | Transmit error counter value |
| rx_err_cnt | input | 8 | Receive error counter value |
| warn_en | input | 1 | Enables setting of the warning interrupt flags |
| tx_warn_mask | input | 1 | Routes the transmit warning flag to `irq` |
| rx_warn_mask | input | 1 | Routes the receive warning flag to `irq` |
| rd_en | input | 1 | Read strobe; clears the error flags |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; a 1 at bit 17 or bit 16 clears that flag |
| rd_data | output | 32 | Current register value |
| irq | output | 1 | Registered interrupt request |

## Verification
The error flags and the warning interrupt flags change on the clock edge that samples the pulse, strobe or counter change. The two status bits follow the counters with no delay. `irq` lags the interrupt flags by one more edge. The bench drives every stimulus at a falling edge and queues the expected word and `irq` for the next rising edge. A monitor compares them 2 ns after that edge. For `irq` the queued value therefore reflects the flags as they stood before the edge. The checks that involve two things on the same edge (read with error, write-clear with warning rise) rely on this same sampling point.

// File: rtl/can_err_stat_pkg.sv
// Package: shared widths, limits and bit positions of the CAN error/status word.
// Positions are given MSB-first (bit 0 = word MSB) and converted to LSB indices.
package can_err_stat_pkg;

    localparam int WORD_W     = 32;
    localparam int CNT_W      = 8;
    localparam int WARN_LIMIT = 96;
    localparam int N_ERR      = 6;
    localparam int N_WARN     = 2;

    // Convert an MSB-first field number into an LSB-based index.
    function automatic int lsb_pos(input int msb_first);
        return WORD_W - 1 - msb_first;
    endfunction

    // Warning channel numbering: 0 = transmit, 1 = receive.
    localparam int CH_TX = 0;
    localparam int CH_RX = 1;

    localparam int POS_TX_INT  = lsb_pos(14);
    localparam int POS_RX_INT  = lsb_pos(15);
    localparam int POS_ERR_TOP = lsb_pos(16);  // bit-1 error; the others follow downward
    localparam int POS_TX_STAT = lsb_pos(22);
    localparam int POS_RX_STAT = lsb_pos(23);

endpackage

// File: rtl/err_flag_bank.sv
// Module: err_flag_bank
// Holds N sticky error flags. A pulse on ev_i sets its flag. A read strobe clears
// every flag, except that a pulse on the same edge as the read wins.
// Assumes the pulses are already qualified and are synchronous to clk.
module err_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         rd_clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Purpose: set on an event, clear on a read, the event having priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (ev_i[g])
                flag_q[g] <= 1'b1;
            else if (rd_clr_i)
                flag_q[g] <= 1'b0;
        end
    end

    assign flags_o = flag_q;

    // R3: with no read, no flag ever drops
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R4: a read with no event leaves all flags cleared
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && ev_i == '0) |=> (flag_q == '0));

    // R4: an event always shows on the next cycle, read or not
    a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(ev_i)) == $past(ev_i)));

endmodule

// File: rtl/warn_monitor.sv
// Module: warn_monitor
// Compares one error counter with the warning limit and gives a live status bit.
// Latches an interrupt flag on a 0-to-1 change of that status while enabled.
// The flag clears through a write-one strobe (clr_i); a new edge wins over the clear.
// Assumes the edge history resets to 0 and keeps tracking even while disabled.
module warn_monitor #(
    parameter int CNT_W = 8,
    parameter int LIMIT = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             en_i,
    input  logic             clr_i,
    output logic             status_o,
    output logic             flag_o
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic status;
    logic prev_q;
    logic flag_q;
    logic rise;

    // Purpose: live threshold compare.
    always_comb status = (cnt_i >= LIMIT_V);

    // Purpose: qualified rising edge of the status bit.
    always_comb rise = en_i && status && !prev_q;

    // Purpose: remember last status for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= status;
    end

    // Purpose: interrupt flag, set on qualified edge, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (rise)  flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign status_o = status;
    assign flag_o   = flag_q;

    // R6: the flag can only rise while enabled
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(en_i));

    // R7: the flag only rises after a 0-to-1 change of the compare
    a_r7_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(status) && !$past(prev_q)));

    // R8: a set flag stays set unless a clear strobe came
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/irq_gen.sv
// Module: irq_gen
// ORs the masked interrupt sources into one registered request line.
// Assumes the masks are static configuration bits, sampled every cycle.
module irq_gen #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flag_i,
    input  logic [N_SRC-1:0] mask_i,
    output logic             irq_o
);

    logic irq_q;

    // Purpose: register the masked OR of the sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_i & mask_i);
    end

    assign irq_o = irq_q;

    // R9: the request never appears without a masked source one cycle earlier
    a_r9_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(flag_i & mask_i) != '0));

endmodule

// File: rtl/can_err_stat.sv
// Module: can_err_stat (top)
// CAN error/status word: six sticky read-clear error flags, two counter-limit
// status bits, two write-one-clear warning interrupt flags and a masked request.
// Assumes the error pulses last one cycle and bit1_exempt is driven by the engine.
module can_err_stat
    import can_err_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_bit1,
    input  logic                ev_bit0,
    input  logic                ev_ack,
    input  logic                ev_crc,
    input  logic                ev_form,
    input  logic                ev_stuff,
    input  logic                bit1_exempt,
    input  logic [CNT_W-1:0]    tx_err_cnt,
    input  logic [CNT_W-1:0]    rx_err_cnt,
    input  logic                warn_en,
    input  logic                tx_warn_mask,
    input  logic                rx_warn_mask,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    output logic                irq
);

    logic [N_ERR-1:0]  err_ev;
    logic [N_ERR-1:0]  err_flags;
    logic [CNT_W-1:0]  cnt    [N_WARN];
    logic [N_WARN-1:0] w_clr;
    logic [N_WARN-1:0] w_stat;
    logic [N_WARN-1:0] w_flag;
    logic [N_WARN-1:0] w_mask;
    int                int_pos [N_WARN];

    // Purpose: order error pulses top bit first; gate bit-1 by its exemption.
    always_comb err_ev = {ev_bit1 & ~bit1_exempt, ev_bit0, ev_ack, ev_crc, ev_form, ev_stuff};

    // Purpose: per-channel counter, mask and interrupt bit position.
    always_comb begin
        cnt[CH_TX]     = tx_err_cnt;
        cnt[CH_RX]     = rx_err_cnt;
        w_mask[CH_TX]  = tx_warn_mask;
        w_mask[CH_RX]  = rx_warn_mask;
        int_pos[CH_TX] = POS_TX_INT;
        int_pos[CH_RX] = POS_RX_INT;
    end

    err_flag_bank #(.N(N_ERR)) u_errs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (err_ev),
        .rd_clr_i (rd_en),
        .flags_o  (err_flags)
    );

    for (genvar c = 0; c < N_WARN; c++) begin : g_warn
        // Purpose: decode the write-one clear for this channel.
        always_comb w_clr[c] = wr_en && wr_data[int_pos[c]];

        warn_monitor #(.CNT_W(CNT_W), .LIMIT(WARN_LIMIT)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_i    (cnt[c]),
            .en_i     (warn_en),
            .clr_i    (w_clr[c]),
            .status_o (w_stat[c]),
            .flag_o   (w_flag[c])
        );
    end

    irq_gen #(.N_SRC(N_WARN)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (w_flag),
        .mask_i (w_mask),
        .irq_o  (irq)
    );

    // Purpose: assemble the read word; unused bits stay zero.
    always_comb begin
        rd_data = '0;
        rd_data[POS_TX_INT]  = w_flag[CH_TX];
        rd_data[POS_RX_INT]  = w_flag[CH_RX];
        rd_data[POS_ERR_TOP -: N_ERR] = err_flags;
        rd_data[POS_TX_STAT] = w_stat[CH_TX];
        rd_data[POS_RX_STAT] = w_stat[CH_RX];
    end

    // R5: an exempt bit-1 pulse never sets the flag on its own
    a_r5_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bit1 && bit1_exempt && !rd_data[POS_ERR_TOP]) |=> !rd_data[POS_ERR_TOP]);

    // R8: a read never clears a warning interrupt flag
    a_r8_read_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rd_data[POS_TX_INT]) |=> rd_data[POS_TX_INT]);

endmodule

// File: tb/can_err_stat_tb_top.sv
// Scoreboard bench: the driver queues the expected word and irq for the next
// rising edge. A monitor pops and compares them 2 ns after that edge.
module can_err_stat_tb_top;

    localparam logic [31:0] TXI = 32'h1 << 17;
    localparam logic [31:0] RXI = 32'h1 << 16;
    localparam logic [31:0] B1  = 32'h1 << 15;
    localparam logic [31:0] B0  = 32'h1 << 14;
    localparam logic [31:0] ACK = 32'h1 << 13;
    localparam logic [31:0] CRC = 32'h1 << 12;
    localparam logic [31:0] FRM = 32'h1 << 11;
    localparam logic [31:0] STF = 32'h1 << 10;
    localparam logic [31:0] TXW = 32'h1 << 9;
    localparam logic [31:0] RXW = 32'h1 << 8;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ev = '0;            // {bit1, bit0, ack, crc, form, stuff}
    logic        exempt = 1'b0;
    logic [7:0]  txc = '0, rxc = '0;
    logic        en = 1'b0, txm = 1'b1, rxm = 1'b1;
    logic        rd = 1'b0, wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        irq;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    can_err_stat dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_bit1(ev[5]), .ev_bit0(ev[4]), .ev_ack(ev[3]),
        .ev_crc(ev[2]), .ev_form(ev[1]), .ev_stuff(ev[0]),
        .bit1_exempt(exempt), .tx_err_cnt(txc), .rx_err_cnt(rxc),
        .warn_en(en), .tx_warn_mask(txm), .rx_warn_mask(rxm),
        .rd_en(rd), .wr_en(wr), .wr_data(wdata),
        .rd_data(rd_data), .irq(irq)
    );

    // Monitor: compare one queued expectation per rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rd_data !== e.rd || irq !== e.irq) begin
                failures++;
                $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                         e.tag, rd_data, irq, e.rd, e.irq);
            end
        end
    end

    // Driver: queue the expectation, cross one edge, drop the pulses.
    task automatic tick(input logic [31:0] erd, input logic eirq, input string tag);
        exp_t e;
        e.rd = erd; e.irq = eirq; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        ev = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(32'h0, 1'b0, "R1 reset state");
        ev = 6'b010100;       tick(B0 | CRC, 1'b0, "R3 bit0+crc set");
                              tick(B0 | CRC, 1'b0, "R3 sticky");
        rd = 1'b1;            tick(32'h0, 1'b0, "R4 read clears");
        ev = 6'b001011;       tick(ACK | FRM | STF, 1'b0, "R3 ack+form+stuff");
        rd = 1'b1; ev = 6'b010000; tick(B0, 1'b0, "R4 event beats read");
        rd = 1'b1;            tick(32'h0, 1'b0, "R4 clear again");
        exempt = 1'b1; ev = 6'b100000; tick(32'h0, 1'b0, "R5 exempt bit1 ignored");
        exempt = 1'b0; ev = 6'b100000; tick(B1, 1'b0, "R5 bit1 counted");
        rd = 1'b1;            tick(32'h0, 1'b0, "R4 clear bit1");
        txc = 8'd95;          tick(32'h0, 1'b0, "R2 tx below limit");
        txc = 8'd96;          tick(TXW, 1'b0, "R6 rise while disabled");
        txc = 8'd95;          tick(32'h0, 1'b0, "R2 tx falls");
        en = 1'b1; txc = 8'd100; tick(TXW | TXI, 1'b0, "R6 tx rise enabled");
                              tick(TXW | TXI, 1'b1, "R9 irq one cycle later");
        wr = 1'b1; wdata = 32'h0; tick(TXW | TXI, 1'b1, "R8 write zero keeps");
        rd = 1'b1;            tick(TXW | TXI, 1'b1, "R8 read keeps warning");
        wr = 1'b1; wdata = TXI; tick(TXW, 1'b1, "R8 write one clears");
                              tick(TXW, 1'b0, "R9 irq drops");
        en = 1'b0; rxc = 8'd120; tick(TXW | RXW, 1'b0, "R2 rx status");
        en = 1'b1;            tick(TXW | RXW, 1'b0, "R7 level not edge");
        rxc = 8'd50;          tick(TXW, 1'b0, "R2 rx falls");
        rxc = 8'd96;          tick(TXW | RXW | RXI, 1'b0, "R6 rx rise enabled");
        rxm = 1'b0;           tick(TXW | RXW | RXI, 1'b0, "R9 masked rx");
        rxm = 1'b1;           tick(TXW | RXW | RXI, 1'b1, "R9 unmasked rx");
        txc = 8'd90; wr = 1'b1; wdata = TXI | RXI; tick(RXW, 1'b1, "R8 clear rx");
        txc = 8'd97; wr = 1'b1; wdata = TXI; tick(TXW | RXW | TXI, 1'b0, "R8 edge beats clear");
                              tick(TXW | RXW | TXI, 1'b1, "R9 tx irq");
        wr = 1'b1; wdata = 32'hFFFF_FFFF; tick(TXW | RXW, 1'b1, "R10 write all ones");
                              tick(TXW | RXW, 1'b0, "R10 unused bits zero");
        @(negedge clk);
        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
        end
    end

endmodule